// File: doc/BRIEF.md
# Windowed Watchdog Supervisor with Trigger and Question-Answer Service

This block supervises a processor through repeating watchdog sequences. Each sequence is a first window followed by a second window, both measured in ticks of a prescaled clock (`TICK_DIV` clock cycles per tick, meant to match 0.55 ms). Software serves the watchdog in one of two ways.

In trigger mode, a deglitched pulse on `trig_pin` serves it, and the pulse has to land in the second window. In question-answer mode, software writes four answer bytes that are derived from the current 4-bit token. Three of them belong in the first window and the last one belongs in the second window.

Every sequence ends with a verdict of good or bad. The verdict moves a saturating fail counter. The fail counter in turn drives a safing-path enable (`safe_drv`, active high) and a sticky reset request. Software selects the mode, sets the two window lengths, and commands the active-state load of the counter.

Top module: `qa_watchdog`

## Requirements
- R1: The first window lasts N1 ticks and the second lasts N2+1 ticks, where N1 is `win1_data` (7 bits) and N2 is `win2_data` (5 bits). A sequence that gets no service ends with a bad verdict at the edge (N1+N2+1)*`TICK_DIV` counted from its start, and not before.
- R2: When `mode_qa`=0, a trigger accepted in the first window gives a bad verdict with `st_early` set. A trigger accepted in the second window gives a good verdict. Either one restarts the sequence. The trigger is accepted one edge after the filter fires.
- R3: The trigger filter fires only after `trig_pin` has been sampled high on `DEGLITCH_CYC` consecutive edges. A shorter high pulse is ignored.
- R4: When `mode_qa`=1, answers with index 3, 2 and 1 must arrive in the first window and answer index 0 must arrive in the second window. An index 3 to 1 answer outside the first window sets `st_late`. An index 0 answer inside the first window sets `st_early`.
- R5: Answers are taken in index order 3, 2, 1, 0. The byte expected for index i is the 8-bit value {token XOR i, NOT token} rotated left by i bits. If any of the four bytes mismatches, the verdict is bad with `st_wrong` set.
- R6: A write to either window configuration restarts the sequence, gives no verdict and discards any answers already given. The fourth answer always ends the sequence, whether or not the answers were correct.
- R7: In question-answer mode, a sequence that ends with fewer than four answers is bad, with `st_late` set.
- R8: `token` resets to 4'h1. It advances as {t[2:0], t[3]^t[0]} after each good question-answer sequence and is otherwise unchanged.
- R9: `fail_cnt` resets to 7. A `go_active` pulse loads 5. A good verdict decrements it with a floor of 0. A bad verdict increments it, saturating at 7.
- R10: `safe_drv` equals `drv_enable` AND (`fail_cnt` <= 4), registered one cycle after the count. So five bad verdicts starting from 0 drive it low.
- R11: A bad verdict that arrives while `fail_cnt` is 7 sets `reset_req`, provided `rst_en` is 1. `reset_req` stays set until `go_active` clears it.
- R12: The status flags are rewritten at every verdict and hold until the next verdict. After a good verdict all three are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_qa | input | 1 | 1 = question-answer service, 0 = trigger service |
| win1_we | input | 1 | Write strobe for the first-window length |
| win1_data | input | 7 | First-window length N1 in ticks |
| win2_we | input | 1 | Write strobe for the second-window length |
| win2_data | input | 5 | Second-window length code N2 (N2+1 ticks) |
| trig_pin | input | 1 | Trigger input, synchronous to clk |
| ans_we | input | 1 | Answer write strobe |
| ans_data | input | 8 | Answer byte |
| go_active | input | 1 | Pulse: enter active state, load fail count 5, clear reset request |
| rst_en | input | 1 | Allows the watchdog to raise the reset request |
| drv_enable | input | 1 | Software permission for the safing output |
| token | output | 4 | Current question token |
| st_early | output | 1 | Last verdict: response too early |
| st_late | output | 1 | Last verdict: response too late or timeout |
| st_wrong | output | 1 | Last verdict: wrong answer |
| fail_cnt | output | 3 | Watchdog fail count |
| safe_drv | output | 1 | Safing-path enable, low while failing |
| reset_req | output | 1 | Sticky reset request |

## Verification
In question-answer mode the bench runs correct sequences, sequences with one corrupted byte, sequences with a final answer that is too early, and sequences whose first answers are late. Each of these tells apart one of the three fault flags and also shows whether the token advances or stays. A sequence of two answers followed by silence, and a window change partway through three answers, separate the timeout path from the restart-without-verdict path. In trigger mode, pulses in each window and a pulse one cycle shorter than the filter length separate good triggers, early triggers and rejected glitches. Runs of bad verdicts with `rst_en` and `drv_enable` toggled show the staged safing and reset actions, the saturation at 7 and the floor at 0.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int TOK_W = 4;
  typedef logic [TOK_W-1:0] token_t;

  // Maximal-length 4-bit sequence over the nonzero values
  function automatic token_t tok_next(token_t t);
    return {t[2:0], t[3] ^ t[0]};
  endfunction

  // Expected byte for answer index idx: rotate-left of {t^idx, ~t} by idx
  function automatic logic [7:0] answer_of(token_t t, logic [1:0] idx);
    logic [15:0] twice;
    logic [7:0]  raw;
    raw   = {t ^ {2'b00, idx}, ~t};
    twice = {raw, raw} << idx;
    return twice[15:8];
  endfunction
endpackage

// File: rtl/wdg_window_timer.sv
module wdg_window_timer #(
  parameter int TICK_DIV = 16,
  parameter int W1_W     = 7,
  parameter int W2_W     = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            restart,
  input  logic [W1_W-1:0] n1,
  input  logic [W2_W-1:0] n2,
  output logic            in_w1,
  output logic            seq_end
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int SEQ_W = W1_W + 1;

  logic [PRE_W-1:0] pre;
  logic [SEQ_W-1:0] tcnt;
  logic             tick;
  logic [SEQ_W-1:0] last;

  assign tick    = (pre == PRE_W'(TICK_DIV - 1));
  assign last    = SEQ_W'(n1) + SEQ_W'(n2);
  assign in_w1   = (tcnt < SEQ_W'(n1));
  assign seq_end = tick && (tcnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre  <= '0;
      tcnt <= '0;
    end else if (tick) begin
      pre  <= '0;
      tcnt <= (tcnt == last) ? '0 : tcnt + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end

  p_tcnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
    tcnt <= last);
  p_restart_zero_r6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (tcnt == '0) && (pre == '0));
endmodule

// File: rtl/wdg_trig_filter.sv
module wdg_trig_filter #(
  parameter int DEGLITCH_CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pulse
);
  localparam int CW = $clog2(DEGLITCH_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(DEGLITCH_CYC - 1);

  logic [CW-1:0] hcnt;
  logic          fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt  <= '0;
      fired <= 1'b0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (!pin) begin
        hcnt  <= '0;
        fired <= 1'b0;
      end else if (hcnt != FULL) begin
        hcnt <= hcnt + 1'b1;
      end else if (!fired) begin
        pulse <= 1'b1;
        fired <= 1'b1;
      end
    end
  end

  p_pulse_needs_high_r3: assert property (@(posedge clk) disable iff (rst)
    pulse |-> $past(pin));
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
endmodule

// File: rtl/wdg_fail_counter.sv
module wdg_fail_counter #(
  parameter int FC_W     = 3,
  parameter int SAFE_LIM = 4,
  parameter int ACT_INIT = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            good,
  input  logic            bad,
  input  logic            rst_en,
  input  logic            drv_en,
  output logic [FC_W-1:0] cnt,
  output logic            safe_drv,
  output logic            reset_req
);
  localparam logic [FC_W-1:0] CMAX = '1;
  localparam logic [FC_W-1:0] LIM  = FC_W'(SAFE_LIM);
  localparam logic [FC_W-1:0] INIT = FC_W'(ACT_INIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= CMAX;
      safe_drv  <= 1'b0;
      reset_req <= 1'b0;
    end else begin
      safe_drv <= drv_en && (cnt <= LIM);
      if (load) begin
        cnt       <= INIT;
        reset_req <= 1'b0;
      end else if (good) begin
        if (cnt != '0) cnt <= cnt - 1'b1;
      end else if (bad) begin
        if (cnt == CMAX) begin
          if (rst_en) reset_req <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_step_by_one_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt != $past(cnt)) && !$past(load) |->
      (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));
  p_load_value_r9: assert property (@(posedge clk) disable iff (rst)
    $past(load) |-> cnt == INIT);
  p_safe_low_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt > LIM) |=> !safe_drv);
  p_reset_cause_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(reset_req) |-> $past(rst_en) && $past(bad) && ($past(cnt) == CMAX));
endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog
  import wdg_pkg::*;
#(
  parameter int TICK_DIV     = 16,
  parameter int DEGLITCH_CYC = 8,
  parameter int W1_W         = 7,
  parameter int W2_W         = 5,
  parameter int FC_W         = 3,
  parameter int W1_RST       = 4,
  parameter int W2_RST       = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_qa,
  input  logic             win1_we,
  input  logic [W1_W-1:0]  win1_data,
  input  logic             win2_we,
  input  logic [W2_W-1:0]  win2_data,
  input  logic             trig_pin,
  input  logic             ans_we,
  input  logic [7:0]       ans_data,
  input  logic             go_active,
  input  logic             rst_en,
  input  logic             drv_enable,
  output logic [TOK_W-1:0] token,
  output logic             st_early,
  output logic             st_late,
  output logic             st_wrong,
  output logic [FC_W-1:0]  fail_cnt,
  output logic             safe_drv,
  output logic             reset_req
);
  logic [W1_W-1:0] n1_q;
  logic [W2_W-1:0] n2_q;
  token_t          token_q;
  logic [1:0]      acnt;
  logic            acc_wrong, acc_early, acc_late;
  logic            in_w1, seq_end, trig_pulse;
  logic            cfg_wr, trig_ev, ans_ev, fin, tmo, restart;
  logic [1:0]      idx;
  logic            now_wrong, now_early, now_late;
  logic            ev_good, ev_bad, f_early, f_late, f_wrong;

  assign cfg_wr    = win1_we | win2_we;
  assign trig_ev   = !mode_qa && trig_pulse && !cfg_wr;
  assign ans_ev    = mode_qa && ans_we && !cfg_wr;
  assign idx       = 2'd3 - acnt;
  assign now_wrong = (ans_data != answer_of(token_q, idx));
  assign now_early = (idx == 2'd0) && in_w1;
  assign now_late  = (idx != 2'd0) && !in_w1;
  assign fin       = ans_ev && (acnt == 2'd3);
  assign tmo       = seq_end && !cfg_wr && !trig_ev && !fin;
  assign restart   = cfg_wr | trig_ev | fin | tmo;

  always_comb begin
    ev_good = 1'b0;
    ev_bad  = 1'b0;
    f_early = 1'b0;
    f_late  = 1'b0;
    f_wrong = 1'b0;
    if (trig_ev) begin
      f_early = in_w1;
      ev_bad  = in_w1;
      ev_good = !in_w1;
    end else if (fin) begin
      f_early = acc_early | now_early;
      f_late  = acc_late  | now_late;
      f_wrong = acc_wrong | now_wrong;
      ev_bad  = f_early | f_late | f_wrong;
      ev_good = !ev_bad;
    end else if (tmo) begin
      f_late = 1'b1;
      ev_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      n1_q      <= W1_W'(W1_RST);
      n2_q      <= W2_W'(W2_RST);
      token_q   <= token_t'(1);
      acnt      <= '0;
      acc_wrong <= 1'b0;
      acc_early <= 1'b0;
      acc_late  <= 1'b0;
      st_early  <= 1'b0;
      st_late   <= 1'b0;
      st_wrong  <= 1'b0;
    end else begin
      if (win1_we) n1_q <= win1_data;
      if (win2_we) n2_q <= win2_data;
      if (restart) begin
        acnt      <= '0;
        acc_wrong <= 1'b0;
        acc_early <= 1'b0;
        acc_late  <= 1'b0;
      end else if (ans_ev) begin
        acnt      <= acnt + 1'b1;
        acc_wrong <= acc_wrong | now_wrong;
        acc_early <= acc_early | now_early;
        acc_late  <= acc_late  | now_late;
      end
      if (fin && ev_good) token_q <= tok_next(token_q);
      if (ev_good || ev_bad) begin
        st_early <= f_early;
        st_late  <= f_late;
        st_wrong <= f_wrong;
      end
    end
  end

  assign token = token_q;

  wdg_window_timer #(.TICK_DIV(TICK_DIV), .W1_W(W1_W), .W2_W(W2_W)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .n1(n1_q), .n2(n2_q),
    .in_w1(in_w1), .seq_end(seq_end)
  );

  wdg_trig_filter #(.DEGLITCH_CYC(DEGLITCH_CYC)) u_filter (
    .clk(clk), .rst(rst), .pin(trig_pin), .pulse(trig_pulse)
  );

  wdg_fail_counter #(.FC_W(FC_W), .SAFE_LIM(4), .ACT_INIT(5)) u_fail (
    .clk(clk), .rst(rst), .load(go_active), .good(ev_good), .bad(ev_bad),
    .rst_en(rst_en), .drv_en(drv_enable), .cnt(fail_cnt),
    .safe_drv(safe_drv), .reset_req(reset_req)
  );

  p_token_step_r8: assert property (@(posedge clk) disable iff (rst)
    (token_q != $past(token_q)) |-> token_q == tok_next($past(token_q)));
  p_flags_clear_good_r12: assert property (@(posedge clk) disable iff (rst)
    $past(ev_good) |-> !st_early && !st_late && !st_wrong);
  p_trig_early_r2: assert property (@(posedge clk) disable iff (rst)
    $past(trig_ev && in_w1) |-> st_early);
  p_timeout_late_r7: assert property (@(posedge clk) disable iff (rst)
    $past(tmo) |-> st_late && !st_early && !st_wrong);
endmodule

// File: tb/qa_watchdog_tb.sv
`timescale 1ns/1ps
module qa_watchdog_tb;
  localparam int TD = 16;
  localparam int DG = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_qa = 1'b1, win1_we = 1'b0, win2_we = 1'b0;
  logic [6:0] win1_data = '0;
  logic [4:0] win2_data = '0;
  logic       trig_pin = 1'b0, ans_we = 1'b0, go_active = 1'b0;
  logic [7:0] ans_data = '0;
  logic       rst_en = 1'b1, drv_enable = 1'b1;
  logic [3:0] token;
  logic       st_early, st_late, st_wrong, safe_drv, reset_req;
  logic [2:0] fail_cnt;

  always #2.5 clk = ~clk;

  qa_watchdog #(.TICK_DIV(TD), .DEGLITCH_CYC(DG)) u_dut (
    .clk(clk), .rst(rst), .mode_qa(mode_qa), .win1_we(win1_we), .win1_data(win1_data),
    .win2_we(win2_we), .win2_data(win2_data), .trig_pin(trig_pin), .ans_we(ans_we),
    .ans_data(ans_data), .go_active(go_active), .rst_en(rst_en), .drv_enable(drv_enable),
    .token(token), .st_early(st_early), .st_late(st_late), .st_wrong(st_wrong),
    .fail_cnt(fail_cnt), .safe_drv(safe_drv), .reset_req(reset_req)
  );

  typedef struct {
    string      tag;
    logic [2:0] fc;
    logic [3:0] tok;
    logic       e, l, w, safe, rreq;
  } exp_t;

  exp_t q[$];
  event smp;
  int   checks = 0, errors = 0, cur = 0;
  bit   done = 0;
  logic [2:0] m_fc = 3'd7;
  logic [3:0] m_tok = 4'h1;
  logic       m_rreq = 1'b0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] tb_ans(logic [3:0] t, int i);
    logic [7:0]  b;
    logic [15:0] d;
    b = {t ^ 4'(i), ~t};
    d = {b, b};
    return d[15-i -: 8];
  endfunction

  // Monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(smp);
      while (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(x.tag, "fail_cnt", 32'(fail_cnt), 32'(x.fc));
        chk(x.tag, "token", 32'(token), 32'(x.tok));
        chk(x.tag, "st_early", 32'(st_early), 32'(x.e));
        chk(x.tag, "st_late", 32'(st_late), 32'(x.l));
        chk(x.tag, "st_wrong", 32'(st_wrong), 32'(x.w));
        chk(x.tag, "safe_drv", 32'(safe_drv), 32'(x.safe));
        chk(x.tag, "reset_req", 32'(reset_req), 32'(x.rreq));
      end
    end
  end

  task automatic step(); @(negedge clk); cur++; endtask
  task automatic goto(int j); while (cur < j - 1) step(); endtask

  task automatic wcfg(logic [6:0] a, logic [4:0] b);
    win1_we = 1'b1; win1_data = a; win2_we = 1'b1; win2_data = b;
    @(negedge clk);
    win1_we = 1'b0; win2_we = 1'b0;
    cur = 0;
  endtask

  task automatic answer(int j, logic [7:0] v);
    goto(j); ans_we = 1'b1; ans_data = v; step(); ans_we = 1'b0;
  endtask

  task automatic trig(int j, int len);
    goto(j); trig_pin = 1'b1; repeat (len) step(); trig_pin = 1'b0;
  endtask

  // Driver: update the model for a verdict at edge J, push it, sample after J+1
  task automatic verdict(string tag, bit good, bit e, bit l, bit w, int j);
    exp_t x;
    if (good) begin
      if (m_fc != 0) m_fc = m_fc - 1'b1;
      if (mode_qa) m_tok = {m_tok[2:0], m_tok[3] ^ m_tok[0]};
    end else begin
      if (m_fc == 3'd7) begin
        if (rst_en) m_rreq = 1'b1;
      end else m_fc = m_fc + 1'b1;
    end
    while (cur < j + 1) step();
    x.tag = tag; x.fc = m_fc; x.tok = m_tok; x.e = e; x.l = l; x.w = w;
    x.safe = drv_enable && (m_fc <= 3'd4); x.rreq = m_rreq;
    q.push_back(x);
    ->smp;
    step();
  endtask

  task automatic qa_seq(string tag, int t3, int t2, int t1, int t0, int bad_k,
                        bit good, bit e, bit l, bit w);
    int tm[4];
    tm[0] = t3; tm[1] = t2; tm[2] = t1; tm[3] = t0;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] v;
      v = tb_ans(m_tok, 3 - k);
      if (k == bad_k) v = v ^ 8'h01;
      answer(tm[k], v);
    end
    verdict(tag, good, e, l, w, t0);
  endtask

  task automatic go_pulse();
    go_active = 1'b1; step(); go_active = 1'b0;
    m_fc = 3'd5; m_rreq = 1'b0;
  endtask

  task automatic short_timeout(string tag);
    wcfg(7'd2, 5'd1);
    verdict(tag, 0, 0, 1, 0, 64);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    step();
    // R9 R8 R10 R11 R12: reset state
    chk("R9 reset", "fail_cnt", 32'(fail_cnt), 32'd7);
    chk("R8 reset", "token", 32'(token), 32'h1);
    chk("R10 reset", "safe_drv", 32'(safe_drv), 32'd0);
    chk("R11 reset", "reset_req", 32'(reset_req), 32'd0);
    chk("R12 reset", "flags", 32'({st_early, st_late, st_wrong}), 32'd0);

    go_pulse();
    step();
    chk("R9 active load", "fail_cnt", 32'(fail_cnt), 32'd5);
    chk("R10 at five", "safe_drv", 32'(safe_drv), 32'd0);

    // R4 R5 R8: good question-answer sequences down to the floor
    for (int n = 0; n < 6; n++) begin
      wcfg(7'd4, 5'd3);
      qa_seq("R4 R5 R9 good sequence", 10, 20, 30, 90, -1, 1, 0, 0, 0);
    end
    wcfg(7'd4, 5'd3);
    qa_seq("R5 wrong byte", 10, 20, 30, 90, 1, 0, 0, 0, 1);
    wcfg(7'd4, 5'd3);
    qa_seq("R4 final too early", 10, 20, 30, 40, -1, 0, 1, 0, 0);
    wcfg(7'd4, 5'd3);
    qa_seq("R4 first answers late", 70, 72, 74, 90, -1, 0, 0, 1, 0);

    // R7 R1: timeout after two answers, not one edge earlier
    wcfg(7'd4, 5'd3);
    answer(10, tb_ans(m_tok, 3));
    answer(20, tb_ans(m_tok, 2));
    goto(128);
    chk("R1 no verdict before end", "fail_cnt", 32'(fail_cnt), 32'(m_fc));
    verdict("R7 timeout", 0, 0, 1, 0, 128);

    // R6: window write discards partial answers without a verdict
    wcfg(7'd4, 5'd3);
    answer(10, tb_ans(m_tok, 3));
    answer(20, tb_ans(m_tok, 2));
    answer(30, tb_ans(m_tok, 1));
    goto(40);
    wcfg(7'd4, 5'd3);
    step();
    chk("R6 restart no verdict", "fail_cnt", 32'(fail_cnt), 32'(m_fc));
    qa_seq("R6 fresh sequence after restart", 10, 20, 30, 90, -1, 1, 0, 0, 0);

    // R1: shorter windows end after (2+1+1)*TD edges
    wcfg(7'd2, 5'd1);
    goto(64);
    chk("R1 short no verdict", "fail_cnt", 32'(fail_cnt), 32'(m_fc));
    verdict("R1 short timeout", 0, 0, 1, 0, 64);

    // R10: reach five, then recover with and without permission
    while (m_fc < 3'd5) short_timeout("R10 bad run");
    wcfg(7'd4, 5'd3);
    qa_seq("R10 recover to four", 10, 20, 30, 90, -1, 1, 0, 0, 0);
    drv_enable = 1'b0;
    wcfg(7'd4, 5'd3);
    qa_seq("R10 no permission", 10, 20, 30, 90, -1, 1, 0, 0, 0);
    drv_enable = 1'b1;

    // R11: reset request at the saturated count, then disabled
    while (m_fc < 3'd7) short_timeout("R9 climb");
    short_timeout("R9 saturate R11 request");
    go_pulse();
    step();
    chk("R11 cleared by active", "reset_req", 32'(reset_req), 32'd0);
    rst_en = 1'b0;
    for (int n = 0; n < 3; n++) short_timeout("R9 climb");
    short_timeout("R11 request disabled");
    rst_en = 1'b1;

    // R2 R3: trigger mode
    mode_qa = 1'b0;
    wcfg(7'd4, 5'd3);
    trig(90 - DG, DG);
    verdict("R2 trigger second window", 1, 0, 0, 0, 90);
    wcfg(7'd4, 5'd3);
    trig(30 - DG, DG);
    verdict("R2 trigger first window", 0, 1, 0, 0, 30);
    wcfg(7'd4, 5'd3);
    trig(90 - DG, DG - 1);
    verdict("R3 glitch rejected", 0, 0, 1, 0, 128);
    wcfg(7'd4, 5'd3);
    trig(90 - DG, DG);
    verdict("R12 flags clear after good", 1, 0, 0, 0, 90);

    step(); step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule